// File: doc/BRIEF.md
# NAND Flash Command Sequencer

This block turns one request at a time (device reset, identification read, status read, page read, page program, block erase) into the ordered command and address cycles of a byte-wide NAND bus. The bus has a command latch, an address latch, a write strobe and a read strobe, and takes in the device's ready/busy line. Geometry inputs set the page size (512 or 2048 bytes), the pages per block (32 for small pages, 64 or 128 for large pages), whether one extra address cycle is sent, and how many blocks the device has. From these the block packs the row address and checks that the requested index is in range.

A request is accepted with a valid/ready handshake. Acceptance waits until the sequencer is idle, the surrounding controller reports ready and the device is not busy. Once the final cycle is issued, the block waits for the device to finish. For erase and program it then issues a status read and judges the result from two status bits. A page program stops after its address cycles and waits for the payload path to report that the data has been written, and only then sends the confirm command. Each request ends with a one-cycle done pulse and a two-bit result code.

Top module: `nand_seq`

## Requirements
- R1: A request is accepted (`req_valid` and `req_ready` both high at a clock edge) only while the sequencer is idle and both `ctrl_ready` and `nand_rb` are high. `req_ready` is high in exactly that case.
- R2: Request codes on `req_op`: 0 reset (command 0xFF), 1 read ID (0x90), 2 read status (0x70), 3 page read (0x00, plus a 0x30 confirm after the address only in large-page mode), 4 program (0x80, plus a 0x10 confirm), 5 erase (0x60, plus a 0xD0 confirm). The confirm always follows the last address byte.
- R3: A page address for read or program is zero column bytes (one in small-page mode, two in large-page mode), then page index bits 7:0, then bits 15:8. Bits 23:16 follow only when `cfg_ext_addr` is high.
- R4: An erase sends no column bytes. The row is the block index shifted left by 5 (small pages), 6 (large, `cfg_normal_blocks` high) or 7 (large, `cfg_normal_blocks` low). Its bytes go out low byte first, and the third byte is sent only when `cfg_ext_addr` is high.
- R5: Each command or address cycle is exactly one clock with `bus_we` high and one of `bus_cle`/`bus_ale` high, and the byte is on `bus_byte`. No more than one of `bus_cle`, `bus_ale`, `bus_re` is high at any time.
- R6: Read ID sends 0x90 and then a single address byte of 0x00. It completes only after the device reports ready.
- R7: Read or program with an index at or above block count times pages per block, erase with an index at or above the block count, and request codes 6 and 7 are all rejected. They return result 2 in the cycle after acceptance, and no bus cycle is issued.
- R8: Erase and program end with a 0x70 command and one read strobe. The result is 0 (pass) when status bit 6 is 1 and bit 0 is 0, and 1 (fail) otherwise.
- R9: A program raises `pay_wait` after its last address cycle. It issues no bus cycle until `pay_done` is seen high, and then it sends 0x10.
- R10: Read status sends 0x70 and one read strobe, and returns result 0. The byte it read appears on `status_byte` from the done pulse until the next status read.
- R11: `done` is high for exactly one cycle per accepted request. Result 1 is produced only by erase or program.
- R12: Reset, read ID, read, erase and program wait `SETTLE` cycles after their last write cycle and then for `nand_rb` high before they complete or read status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request can be accepted |
| req_op | input | 3 | Request code (R2) |
| req_index | input | IDX_W | Page index, or block index for erase |
| cfg_small_pages | input | 1 | 1: 512-byte pages, 32 pages per block |
| cfg_normal_blocks | input | 1 | Large pages: 1 gives 64, 0 gives 128 pages per block |
| cfg_ext_addr | input | 1 | Send the extra row address byte |
| cfg_block_count | input | BLK_W | Number of blocks on the device |
| ctrl_ready | input | 1 | Surrounding controller ready |
| nand_rb | input | 1 | Device ready (1) / busy (0) |
| bus_cle | output | 1 | Command latch |
| bus_ale | output | 1 | Address latch |
| bus_we | output | 1 | Write strobe |
| bus_re | output | 1 | Read strobe |
| bus_byte | output | 8 | Command or address byte |
| bus_din | input | 8 | Byte read from the device |
| pay_wait | output | 1 | Program waiting for payload |
| pay_done | input | 1 | Payload written |
| done | output | 1 | Request complete (one cycle) |
| result | output | 2 | 0 ok, 1 fail, 2 rejected |
| status_byte | output | 8 | Last status byte read |

## Verification
The assertions take for granted that `nand_rb` drops no later than `SETTLE` cycles after a write cycle that starts device work. They also assume `bus_din` holds the status byte during the read strobe. The device model in the bench goes busy at the strobe edge itself, for a random 0 to 6 cycles, and drives `bus_din` with a status value chosen for each request. `pay_done` is raised only while `pay_wait` is high, after a random delay. The configuration and index change only while the block is idle. Indices are drawn at the range limit, one below it, inside it and anywhere in 24 bits.

// File: rtl/nand_seq.sv
module nand_seq #(
  parameter int IDX_W  = 24,
  parameter int BLK_W  = 16,
  parameter int SETTLE = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [2:0]       req_op,
  input  logic [IDX_W-1:0] req_index,
  input  logic             cfg_small_pages,
  input  logic             cfg_normal_blocks,
  input  logic             cfg_ext_addr,
  input  logic [BLK_W-1:0] cfg_block_count,
  input  logic             ctrl_ready,
  input  logic             nand_rb,
  output logic             bus_cle,
  output logic             bus_ale,
  output logic             bus_we,
  output logic             bus_re,
  output logic [7:0]       bus_byte,
  input  logic [7:0]       bus_din,
  output logic             pay_wait,
  input  logic             pay_done,
  output logic             done,
  output logic [1:0]       result,
  output logic [7:0]       status_byte
);
  localparam int SW = (SETTLE < 2) ? 1 : $clog2(SETTLE + 1);
  localparam logic [2:0] OP_RST = 3'd0, OP_ID = 3'd1, OP_STAT = 3'd2,
                         OP_READ = 3'd3, OP_PROG = 3'd4, OP_ERASE = 3'd5;
  localparam logic [1:0] RES_OK = 2'd0, RES_FAIL = 2'd1, RES_BAD = 2'd2;

  typedef enum logic [3:0] {
    S_IDLE, S_CMD1, S_ADDR, S_PAY, S_CMD2, S_SETTLE, S_WAIT, S_SCMD, S_SRD, S_DONE
  } st_t;

  st_t         st;
  logic [2:0]  op_q;
  logic [7:0]  cmd1_q, cmd2_q;
  logic        has2_q;
  logic [39:0] addr_q;
  logic [2:0]  acnt_q;
  logic [1:0]  res_q;
  logic [7:0]  stat_q;
  logic [SW-1:0] cnt;

  logic [2:0]  shift_c, acnt_c;
  logic [63:0] pages_c;
  logic [23:0] row_c;
  logic [39:0] abytes_c;
  logic [7:0]  c1_c, c2_c;
  logic        has2_c, bad_c;
  logic        accept;

  assign req_ready = (st == S_IDLE) && ctrl_ready && nand_rb;
  assign accept    = req_valid && req_ready;

  always_comb begin
    shift_c  = cfg_small_pages ? 3'd5 : (cfg_normal_blocks ? 3'd6 : 3'd7);
    pages_c  = 64'(cfg_block_count) << shift_c;
    row_c    = 24'(req_index);
    abytes_c = '0;
    acnt_c   = '0;
    c1_c     = 8'h00;
    c2_c     = 8'h00;
    has2_c   = 1'b0;
    bad_c    = 1'b0;
    if (req_op == OP_READ || req_op == OP_PROG) begin
      if (cfg_small_pages) begin
        abytes_c = {8'h00, row_c, 8'h00};
        acnt_c   = 3'd3 + {2'b00, cfg_ext_addr};
      end else begin
        abytes_c = {row_c, 16'h0000};
        acnt_c   = 3'd4 + {2'b00, cfg_ext_addr};
      end
      bad_c = 64'(req_index) >= pages_c;
    end
    case (req_op)
      OP_RST:  c1_c = 8'hFF;
      OP_ID:   begin c1_c = 8'h90; acnt_c = 3'd1; end
      OP_STAT: c1_c = 8'h70;
      OP_READ: begin c1_c = 8'h00; c2_c = 8'h30; has2_c = !cfg_small_pages; end
      OP_PROG: begin c1_c = 8'h80; c2_c = 8'h10; has2_c = 1'b1; end
      OP_ERASE: begin
        c1_c     = 8'h60;
        c2_c     = 8'hD0;
        has2_c   = 1'b1;
        abytes_c = {16'h0000, row_c << shift_c};
        acnt_c   = 3'd2 + {2'b00, cfg_ext_addr};
        bad_c    = 64'(req_index) >= 64'(cfg_block_count);
      end
      default: bad_c = 1'b1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      op_q   <= '0;
      cmd1_q <= '0;
      cmd2_q <= '0;
      has2_q <= 1'b0;
      addr_q <= '0;
      acnt_q <= '0;
      res_q  <= RES_OK;
      stat_q <= '0;
      cnt    <= '0;
    end else begin
      cnt <= '0;
      case (st)
        S_IDLE: if (accept) begin
          op_q   <= req_op;
          cmd1_q <= c1_c;
          cmd2_q <= c2_c;
          has2_q <= has2_c;
          addr_q <= abytes_c;
          acnt_q <= acnt_c;
          if (bad_c) begin
            res_q <= RES_BAD;
            st    <= S_DONE;
          end else begin
            st <= S_CMD1;
          end
        end
        S_CMD1: begin
          if (acnt_q != 3'd0)      st <= S_ADDR;
          else if (op_q == OP_STAT) st <= S_SRD;
          else                      st <= S_SETTLE;
        end
        S_ADDR: begin
          addr_q <= addr_q >> 8;
          acnt_q <= acnt_q - 3'd1;
          if (acnt_q == 3'd1) begin
            if (op_q == OP_PROG) st <= S_PAY;
            else if (has2_q)     st <= S_CMD2;
            else                 st <= S_SETTLE;
          end
        end
        S_PAY:    if (pay_done) st <= S_CMD2;
        S_CMD2:   st <= S_SETTLE;
        S_SETTLE: begin
          cnt <= cnt + 1'b1;
          if (cnt == SW'(SETTLE - 1)) st <= S_WAIT;
        end
        S_WAIT: if (nand_rb) begin
          if (op_q == OP_ERASE || op_q == OP_PROG) st <= S_SCMD;
          else begin
            res_q <= RES_OK;
            st    <= S_DONE;
          end
        end
        S_SCMD: st <= S_SRD;
        S_SRD: begin
          stat_q <= bus_din;
          if (op_q == OP_STAT) res_q <= RES_OK;
          else res_q <= (bus_din[6] && !bus_din[0]) ? RES_OK : RES_FAIL;
          st <= S_DONE;
        end
        S_DONE:  st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  assign bus_cle  = (st == S_CMD1) || (st == S_CMD2) || (st == S_SCMD);
  assign bus_ale  = (st == S_ADDR);
  assign bus_we   = bus_cle || bus_ale;
  assign bus_re   = (st == S_SRD);
  assign bus_byte = (st == S_CMD1) ? cmd1_q :
                    (st == S_CMD2) ? cmd2_q :
                    (st == S_SCMD) ? 8'h70  :
                    (st == S_ADDR) ? addr_q[7:0] : 8'h00;
  assign pay_wait    = (st == S_PAY);
  assign done        = (st == S_DONE);
  assign result      = res_q;
  assign status_byte = stat_q;

  // R5
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({bus_cle, bus_ale, bus_re}));

  // R11
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R11
  fail_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && result == RES_FAIL) |-> (op_q == OP_ERASE || op_q == OP_PROG));

  // R7
  reject_fast_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && result == RES_BAD) |-> ($past(st) == S_IDLE && $past(req_valid)));

  // R9
  pay_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pay_wait && !pay_done) |=> !bus_we);

  // R12
  status_after_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_SCMD) |-> $past(nand_rb));
endmodule

// File: tb/nand_seq_tb.sv
module nand_seq_tb;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rst_n, req_valid, req_ready;
  logic [2:0]  req_op;
  logic [23:0] req_index;
  logic        cfg_small_pages, cfg_normal_blocks, cfg_ext_addr;
  logic [15:0] cfg_block_count;
  logic        ctrl_ready, nand_rb;
  logic        bus_cle, bus_ale, bus_we, bus_re;
  logic [7:0]  bus_byte, bus_din;
  logic        pay_wait, pay_done, done;
  logic [1:0]  result;
  logic [7:0]  status_byte;

  nand_seq u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_index(req_index), .cfg_small_pages(cfg_small_pages),
    .cfg_normal_blocks(cfg_normal_blocks), .cfg_ext_addr(cfg_ext_addr),
    .cfg_block_count(cfg_block_count), .ctrl_ready(ctrl_ready), .nand_rb(nand_rb),
    .bus_cle(bus_cle), .bus_ale(bus_ale), .bus_we(bus_we), .bus_re(bus_re),
    .bus_byte(bus_byte), .bus_din(bus_din), .pay_wait(pay_wait), .pay_done(pay_done),
    .done(done), .result(result), .status_byte(status_byte)
  );

  int checks = 0, fails = 0;
  int cycles = 0;

  logic [8:0] lg [0:16383];
  int ln = 0;
  int busy = 0;
  int pcnt = 0, pdelay = 0, pay_ln = -1;
  int re_cnt = 0;

  assign nand_rb = (busy == 0);

  always @(posedge clk) begin
    if (!rst_n) busy <= 0;
    else if (bus_we && !(bus_cle && bus_byte == 8'h70)) busy <= int'($urandom_range(0, 6));
    else if (busy != 0) busy <= busy - 1;
    if (bus_we && ln < 16384) begin
      lg[ln] <= {bus_ale, bus_byte};
      ln <= ln + 1;
    end
    if (bus_re) re_cnt <= re_cnt + 1;
  end

  always @(negedge clk) begin
    if (pay_wait) begin
      if (pcnt == pdelay) begin
        pay_done = 1'b1;
        pay_ln = ln;
      end else pay_done = 1'b0;
      pcnt = pcnt + 1;
    end else begin
      pay_done = 1'b0;
      pcnt = 0;
    end
  end

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      $display("FAIL watchdog: actual hung expected completion");
      fails = fails + 1;
      summary();
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks = checks + 1;
    if (!ok) begin
      fails = fails + 1;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  logic [8:0] ex [0:9];
  int en;

  task automatic push(input bit is_addr, input logic [7:0] b);
    ex[en] = {is_addr, b};
    en = en + 1;
  endtask

  function automatic int shift_of(bit sm, bit nb);
    return sm ? 5 : (nb ? 6 : 7);
  endfunction

  function automatic int exp_result(int op, int idx, int bc, bit sm, bit nb, logic [7:0] st);
    longint lim = longint'(bc) << shift_of(sm, nb);
    if (op > 5) return 2;
    if ((op == 3 || op == 4) && longint'(idx) >= lim) return 2;
    if (op == 5 && idx >= bc) return 2;
    if (op == 4 || op == 5) return (st[6] && !st[0]) ? 0 : 1;
    return 0;
  endfunction

  task automatic build_seq(input int op, input int idx, input bit sm, input bit nb, input bit xa);
    logic [23:0] row;
    en = 0;
    case (op)
      0: push(0, 8'hFF);
      1: begin push(0, 8'h90); push(1, 8'h00); end
      2: push(0, 8'h70);
      3, 4: begin
        push(0, op == 3 ? 8'h00 : 8'h80);
        push(1, 8'h00);
        if (!sm) push(1, 8'h00);
        row = 24'(idx);
        push(1, row[7:0]);
        push(1, row[15:8]);
        if (xa) push(1, row[23:16]);
        if (op == 3 && !sm) push(0, 8'h30);
        if (op == 4) begin push(0, 8'h10); push(0, 8'h70); end
      end
      5: begin
        push(0, 8'h60);
        row = 24'(idx) << shift_of(sm, nb);
        push(1, row[7:0]);
        push(1, row[15:8]);
        if (xa) push(1, row[23:16]);
        push(0, 8'hD0);
        push(0, 8'h70);
      end
      default: ;
    endcase
  endtask

  task automatic run_op(input int op, input int idx, input int bc, input bit sm,
                        input bit nb, input bit xa, input logic [7:0] st);
    int base, re0, er, nlog, waitc;
    bit seq_ok;
    @(negedge clk);
    cfg_small_pages = sm; cfg_normal_blocks = nb; cfg_ext_addr = xa;
    cfg_block_count = 16'(bc); req_op = 3'(op); req_index = 24'(idx);
    bus_din = st; pdelay = int'($urandom_range(0, 5)); pay_ln = -1;
    req_valid = 1'b1;
    forever begin
      if (req_ready) begin
        // R1
        if (!(ctrl_ready && nand_rb)) check(0, "R1", 1, 0);
        base = ln; re0 = re_cnt;
        @(negedge clk);
        break;
      end
      ctrl_ready = ($urandom_range(0, 3) != 0);
      @(negedge clk);
    end
    req_valid = 1'b0;
    ctrl_ready = 1'b1;
    waitc = 0;
    while (!done && waitc < 500) begin
      @(negedge clk);
      waitc = waitc + 1;
    end
    er = exp_result(op, idx, bc, sm, nb, st);
    // R11 R7 R8
    check(done && int'(result) == er, er == 2 ? "R7" : (op == 4 || op == 5 ? "R8" : "R11"),
          int'(result), er);
    if (er == 2) en = 0; else build_seq(op, idx, sm, nb, xa);
    nlog = ln - base;
    seq_ok = (nlog == en);
    for (int i = 0; i < en && seq_ok; i++) if (lg[base + i] != ex[i]) seq_ok = 0;
    // R2 R3 R4 R6
    check(seq_ok, op == 5 ? "R4" : (op == 1 ? "R6" : (op == 3 || op == 4 ? "R3" : "R2")),
          nlog, en);
    if (er != 2 && (op == 2 || op == 4 || op == 5)) begin
      // R10 one read strobe
      check(re_cnt - re0 == 1, "R10", re_cnt - re0, 1);
      if (op == 2) check(status_byte == st, "R10", int'(status_byte), int'(st));
    end
    if (er != 2 && op == 4) begin
      // R9 payload done lands right before the 0x10 confirm
      check(pay_ln - base == en - 2, "R9", pay_ln - base, en - 2);
    end
    if (er != 2 && op != 2) begin
      // R12
      check(nand_rb || op == 4 || op == 5, "R12", int'(nand_rb), 1);
    end
    @(negedge clk);
    // R11 pulse length
    check(!done, "R11", int'(done), 0);
  endtask

  logic [7:0] stats [0:5] = '{8'h40, 8'h41, 8'h00, 8'hC0, 8'h01, 8'hE0};

  initial begin
    void'($urandom(32'd2024));
    rst_n = 1'b0; req_valid = 1'b0; req_op = '0; req_index = '0;
    cfg_small_pages = 1'b0; cfg_normal_blocks = 1'b1; cfg_ext_addr = 1'b0;
    cfg_block_count = 16'd8; ctrl_ready = 1'b1; bus_din = 8'h40; pay_done = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(req_ready && !done && !bus_we && !bus_re && !pay_wait, "R1", int'(req_ready), 1);

    // directed corners
    run_op(0, 0, 8, 0, 1, 0, 8'h40);
    run_op(1, 0, 8, 1, 0, 1, 8'h40);
    run_op(2, 0, 8, 0, 1, 0, 8'h5A);
    run_op(3, 32 * 8 - 1, 8, 1, 0, 1, 8'h40);
    run_op(3, 32 * 8, 8, 1, 0, 1, 8'h40);
    run_op(3, 128 * 4 - 1, 4, 0, 0, 0, 8'h40);
    run_op(4, 64 * 3 - 1, 3, 0, 1, 1, 8'h40);
    run_op(4, 5, 3, 0, 1, 0, 8'h41);
    run_op(5, 9, 10, 0, 0, 1, 8'h40);
    run_op(5, 10, 10, 0, 0, 1, 8'h40);
    run_op(5, 300, 400, 1, 0, 1, 8'h00);
    run_op(6, 0, 8, 0, 1, 0, 8'h40);
    run_op(7, 0, 8, 0, 1, 0, 8'h40);

    for (int n = 0; n < 300; n++) begin
      int op, bc, idx, lim, k;
      bit sm, nb, xa;
      op = int'($urandom_range(0, 7));
      sm = 1'($urandom_range(0, 1));
      nb = 1'($urandom_range(0, 1));
      xa = 1'($urandom_range(0, 1));
      bc = int'($urandom_range(1, 600));
      lim = (op == 5) ? bc : (bc << shift_of(sm, nb));
      k = int'($urandom_range(0, 3));
      case (k)
        0: idx = int'($urandom_range(0, lim - 1));
        1: idx = lim - 1;
        2: idx = lim;
        default: idx = int'($urandom_range(0, 24'hFFFFFF));
      endcase
      idx = idx & 32'hFFFFFF;
      run_op(op, idx, bc, sm, nb, xa, stats[$urandom_range(0, 5)]);
    end
    summary();
  end
endmodule